// File: doc/BRIEF.md
# Dual-Port Word Memory with Location Contention Flags

This block is a word memory with two fully independent access ports, called left and right. Each port has its own select, direction, output-enable, address and data lines. Either port may read or write any word in any cycle. When both ports present an access to the same word in the same cycle, an arbitration unit picks one owner and flags the other port as busy. A busy port's write is dropped, and its read still returns a word but marks it as untrustworthy.

Arbitration can run in one of two roles. In the master role the block decides contention itself and pulls the shared busy lines low. In the slave role it never pulls the lines; it reads them and uses them to gate its own writes. Several blocks side by side can therefore share the master's decisions and form one wider word. The busy lines are modelled as open-drain: each block has a pull-down request output, and the resolved wired line comes back as an active-low input. A single clock stands in for the asynchronous timing. Each access is captured on a rising edge. Busy is decided combinationally from the access being presented, and read results appear after that edge.

Top module: `twin_port_ram`

## Requirements
- R1: The memory holds 2**AW words (AW = 12 by default, so 4096) of DW bits (8 or 9). A word written at any address, including the highest address 12'hFFF, is returned by a later read of that address. Read data is shown on the rising edge after the read is presented.
- R2: When the two ports present different addresses, both accesses complete in the same cycle and neither busy request is raised.
- R3: Control encoding per port: a port is active when cs_n = 0. rd_wr_n = 1 selects a read and 0 a write. oe_n = 0 enables read output.
- R4: In the master role, busy_drv = 1 means the block pulls that port's busy line low. Exactly one of the two requests is raised when both ports are active at the same address, and neither is raised otherwise.
- R5: If both ports arrive at a shared address together, the left port wins and only the right port is busy.
- R6: A right port that accessed an address unopposed in the previous cycle and presents it again keeps that address, so an arriving left port is busy. In every other collision the right port is busy.
- R7: Busy is lifted for the first access presented after the owning port deselects or moves to another address.
- R8: A write from a busy port leaves memory unchanged.
- R9: A read from a busy port still returns the word. Its rd_stale output is 1 on the edge when the data is shown.
- R10: rd_en is 1 on the edge after an access only if that access was active, a read, and had oe_n = 0. It is 0 after a write, after an idle port, and after a read with oe_n = 1.
- R11: In the slave role (role_i = 0) busy_drv is always 0. The block treats a low busy_line_n as busy for that port: it suppresses the port's write and flags its read as stale.
- R12: During reset and after it, rd_en, rd_stale and busy_drv are 0 until an access says otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| role_i | input | 1 | 1 = master role, 0 = slave role |
| l_cs_n | input | 1 | Left select, active low |
| l_rd_wr_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data |
| l_rd_en | output | 1 | Left read data is driven (models the pad enable) |
| l_rd_stale | output | 1 | Left read was made while busy |
| l_busy_drv | output | 1 | Left busy pull-down request |
| l_busy_line_n | input | 1 | Resolved left busy wired line, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rd_wr_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data |
| r_rd_en | output | 1 | Right read data is driven |
| r_rd_stale | output | 1 | Right read was made while busy |
| r_busy_drv | output | 1 | Right busy pull-down request |
| r_busy_line_n | input | 1 | Resolved right busy wired line, active low |

## Verification
A wrong ownership register shows at the ports in the same cycle the contention is presented: the busy request lands on the wrong side. One edge later the wrong write lands in memory, and the first read of that word exposes it. A wrong read-flag register appears one edge after the access as a bad rd_en or rd_stale. A corrupted word stays hidden until that address is next read, so the bench keeps a reference copy per instance and compares every read. The master and slave instances share their busy lines, so a slave that ignores the lines, or pulls them itself, shows up as a diverging stored word or a stray request.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  localparam int NPORTS  = 2;
  localparam int P_LEFT  = 0;
  localparam int P_RIGHT = 1;
endpackage

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
  import tpr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  role_e                       role_i,
  input  logic [NPORTS-1:0]           act_i,
  input  logic [NPORTS-1:0][AW-1:0]   addr_i,
  input  logic [NPORTS-1:0]           line_n_i,
  output logic [NPORTS-1:0]           busy_o,
  output logic [NPORTS-1:0]           drv_o
);
  // Only the right side's ownership matters: the left side wins every other case (R5, R6)
  logic          own_q, own_d;
  logic [AW-1:0] held_q;
  logic          same_loc, r_keeps;
  logic [NPORTS-1:0] arb;

  always_comb begin
    same_loc = act_i[P_LEFT] & act_i[P_RIGHT] & (addr_i[P_LEFT] == addr_i[P_RIGHT]);
    r_keeps  = own_q & (held_q == addr_i[P_RIGHT]);
    arb[P_LEFT]  = same_loc & r_keeps;
    arb[P_RIGHT] = same_loc & ~r_keeps;
  end

  // Master decides itself; slave obeys the wired lines (R11)
  always_comb begin
    if (role_i == ROLE_MASTER) begin
      busy_o = arb;
      drv_o  = arb;
    end else begin
      busy_o = ~line_n_i;
      drv_o  = '0;
    end
    own_d = act_i[P_RIGHT] & ~busy_o[P_RIGHT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= own_d;
  end

  always_ff @(posedge clk) begin
    if (own_d) held_q <= addr_i[P_RIGHT];
  end
endmodule

// File: rtl/tpr_array.sv
module tpr_array
  import tpr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic [NPORTS-1:0]          we_i,
  input  logic [NPORTS-1:0]          re_i,
  input  logic [NPORTS-1:0][AW-1:0]  addr_i,
  input  logic [NPORTS-1:0][DW-1:0]  wdata_i,
  output logic [NPORTS-1:0][DW-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Arbitration guarantees the two write ports never hit one word together
  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++) begin
      if (we_i[i]) mem[addr_i[i]] <= wdata_i[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++) begin
      if (re_i[i]) rdata_o[i] <= mem[addr_i[i]];
    end
  end
endmodule

// File: rtl/tpr_rdflags.sv
module tpr_rdflags (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic oe_n_i,
  input  logic busy_i,
  output logic rd_en_o,
  output logic stale_o
);
  logic en_d, stale_d;

  always_comb begin
    en_d    = rd_i & ~oe_n_i;        // R10
    stale_d = rd_i & ~oe_n_i & busy_i; // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_o <= 1'b0;
      stale_o <= 1'b0;
    end else begin
      rd_en_o <= en_d;
      stale_o <= stale_d;
    end
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          role_i,
  input  logic          l_cs_n,
  input  logic          l_rd_wr_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rd_en,
  output logic          l_rd_stale,
  output logic          l_busy_drv,
  input  logic          l_busy_line_n,
  input  logic          r_cs_n,
  input  logic          r_rd_wr_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rd_en,
  output logic          r_rd_stale,
  output logic          r_busy_drv,
  input  logic          r_busy_line_n
);
  logic [1:0] rst_pipe;
  logic       srst_n;
  role_e      role;

  logic [NPORTS-1:0]         act, rd_req, wr_req, oe_n_v, busy, drv, line_n, en_v, stale_v;
  logic [NPORTS-1:0][AW-1:0] addr_v;
  logic [NPORTS-1:0][DW-1:0] wdata_v, rdata_v;

  // Asynchronous assert, synchronous release (R12)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];
  assign role   = role_e'(role_i);

  // R3: per-port control decode
  always_comb begin
    act[P_LEFT]      = ~l_cs_n;
    act[P_RIGHT]     = ~r_cs_n;
    addr_v[P_LEFT]   = l_addr;
    addr_v[P_RIGHT]  = r_addr;
    wdata_v[P_LEFT]  = l_wdata;
    wdata_v[P_RIGHT] = r_wdata;
    oe_n_v[P_LEFT]   = l_oe_n;
    oe_n_v[P_RIGHT]  = r_oe_n;
    line_n[P_LEFT]   = l_busy_line_n;
    line_n[P_RIGHT]  = r_busy_line_n;
    rd_req[P_LEFT]   = act[P_LEFT]  &  l_rd_wr_n;
    rd_req[P_RIGHT]  = act[P_RIGHT] &  r_rd_wr_n;
    wr_req[P_LEFT]   = act[P_LEFT]  & ~l_rd_wr_n & ~busy[P_LEFT];  // R8
    wr_req[P_RIGHT]  = act[P_RIGHT] & ~r_rd_wr_n & ~busy[P_RIGHT]; // R8
  end

  tpr_arbiter #(.AW(AW)) u_arb (
    .clk      (clk),
    .rst_n    (srst_n),
    .role_i   (role),
    .act_i    (act),
    .addr_i   (addr_v),
    .line_n_i (line_n),
    .busy_o   (busy),
    .drv_o    (drv)
  );

  tpr_array #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .we_i    (wr_req),
    .re_i    (rd_req),
    .addr_i  (addr_v),
    .wdata_i (wdata_v),
    .rdata_o (rdata_v)
  );

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_flags
    tpr_rdflags u_flags (
      .clk     (clk),
      .rst_n   (srst_n),
      .rd_i    (rd_req[gp]),
      .oe_n_i  (oe_n_v[gp]),
      .busy_i  (busy[gp]),
      .rd_en_o (en_v[gp]),
      .stale_o (stale_v[gp])
    );
  end

  assign l_rdata    = rdata_v[P_LEFT];
  assign r_rdata    = rdata_v[P_RIGHT];
  assign l_rd_en    = en_v[P_LEFT];
  assign r_rd_en    = en_v[P_RIGHT];
  assign l_rd_stale = stale_v[P_LEFT];
  assign r_rd_stale = stale_v[P_RIGHT];
  assign l_busy_drv = drv[P_LEFT];
  assign r_busy_drv = drv[P_RIGHT];
endmodule

// File: rtl/tpr_checks.sv
module tpr_checks #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          role_i,
  input logic          l_cs_n,
  input logic          l_rd_wr_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          l_rd_en,
  input logic          l_rd_stale,
  input logic          l_busy_drv,
  input logic          l_busy_line_n,
  input logic          r_cs_n,
  input logic          r_rd_wr_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          r_rd_en,
  input logic          r_rd_stale,
  input logic          r_busy_drv,
  input logic          r_busy_line_n
);
  logic same_loc;
  assign same_loc = !l_cs_n && !r_cs_n && (l_addr == r_addr);

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (role_i && same_loc) |-> (l_busy_drv != r_busy_drv)); // R4
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_drv || r_busy_drv) |-> same_loc); // R4
  AST_TIE_GOES_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (role_i && same_loc && $past(r_cs_n)) |-> r_busy_drv); // R5
  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (role_i && same_loc && $past(role_i && !r_cs_n && !r_busy_drv) && (r_addr == $past(r_addr)))
      |-> l_busy_drv); // R6
  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !role_i |-> !(l_busy_drv || r_busy_drv)); // R11
  AST_L_RDEN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd_en |-> $past(!l_cs_n && l_rd_wr_n && !l_oe_n)); // R10
  AST_R_RDEN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd_en |-> $past(!r_cs_n && r_rd_wr_n && !r_oe_n)); // R10
  AST_L_STALE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd_stale |-> $past(role_i ? l_busy_drv : !l_busy_line_n)); // R9
  AST_R_STALE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd_stale |-> $past(role_i ? r_busy_drv : !r_busy_line_n)); // R9
endmodule

bind twin_port_ram tpr_checks #(.AW(AW)) u_chk (.*);

// File: tb/sim_twin_port_ram.sv
`timescale 1ns/1ps
module sim_twin_port_ram;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic l_cs_n, l_rw, l_oe_n, r_cs_n, r_rw, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd, l_wd1, r_wd1;
  logic pull_l, pull_r;

  logic [DW-1:0] l_rd0, r_rd0, l_rd1, r_rd1;
  logic l_en0, r_en0, l_en1, r_en1, l_st0, r_st0, l_st1, r_st1;
  logic l_drv0, r_drv0, l_drv1, r_drv1;
  logic line_l_n, line_r_n;

  // Wired-OR open-drain lines shared by both instances and the bench
  assign line_l_n = ~(l_drv0 | l_drv1 | pull_l);
  assign line_r_n = ~(r_drv0 | r_drv1 | pull_r);
  assign l_wd1 = ~l_wd;
  assign r_wd1 = ~r_wd;

  twin_port_ram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .role_i(1'b1),
    .l_cs_n(l_cs_n), .l_rd_wr_n(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wd),
    .l_rdata(l_rd0), .l_rd_en(l_en0), .l_rd_stale(l_st0), .l_busy_drv(l_drv0), .l_busy_line_n(line_l_n),
    .r_cs_n(r_cs_n), .r_rd_wr_n(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wd),
    .r_rdata(r_rd0), .r_rd_en(r_en0), .r_rd_stale(r_st0), .r_busy_drv(r_drv0), .r_busy_line_n(line_r_n)
  );

  twin_port_ram #(.AW(AW), .DW(DW)) u1 (
    .clk(clk), .rst_n(rst_n), .role_i(1'b0),
    .l_cs_n(l_cs_n), .l_rd_wr_n(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wd1),
    .l_rdata(l_rd1), .l_rd_en(l_en1), .l_rd_stale(l_st1), .l_busy_drv(l_drv1), .l_busy_line_n(line_l_n),
    .r_cs_n(r_cs_n), .r_rd_wr_n(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wd1),
    .r_rdata(r_rd1), .r_rd_en(r_en1), .r_rd_stale(r_st1), .r_busy_drv(r_drv1), .r_busy_line_n(line_r_n)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model state
  logic [DW-1:0] ref0 [DEPTH];
  logic [DW-1:0] ref1 [DEPTH];
  bit kn0 [DEPTH];
  bit kn1 [DEPTH];
  bit own_r_m = 1'b0;
  logic [AW-1:0] held_r_m = '0;

  typedef struct {
    bit en_l, en_r, st0l, st0r, st1l, st1r, k0l, k0r, k1l, k1r;
    logic [DW-1:0] d0l, d0r, d1l, d1r;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  // Driver: present one access pair, check busy, push expected read results
  task automatic cycle(input bit lc, input bit lrd, input bit loe, input logic [AW-1:0] la,
                       input logic [DW-1:0] ld, input bit rc, input bit rrd, input bit roe,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rdv,
                       input bit pl, input bit pr, input string tag);
    bit same, keep, bl, br, b1l, b1r;
    exp_t e;
    @(negedge clk);
    l_cs_n = ~lc; l_rw = lrd; l_oe_n = ~loe; l_addr = la; l_wd = ld;
    r_cs_n = ~rc; r_rw = rrd; r_oe_n = ~roe; r_addr = ra; r_wd = rdv;
    pull_l = pl; pull_r = pr;
    #1;
    same = lc && rc && (la == ra);
    keep = own_r_m && (held_r_m == ra);
    bl = same && keep;
    br = same && !keep;
    b1l = bl || pl;
    b1r = br || pr;
    chk(l_drv0 == bl, {tag, " R4 left busy request"}, 32'(l_drv0), 32'(bl));
    chk(r_drv0 == br, {tag, " R4 right busy request"}, 32'(r_drv0), 32'(br));
    chk(!(l_drv1 || r_drv1), {tag, " R11 slave requests"}, {30'd0, l_drv1, r_drv1}, 32'd0);
    e.en_l = lc && lrd && loe;
    e.en_r = rc && rrd && roe;
    e.st0l = e.en_l && bl;  e.st0r = e.en_r && br;
    e.st1l = e.en_l && b1l; e.st1r = e.en_r && b1r;
    e.d0l = ref0[la]; e.k0l = kn0[la]; e.d1l = ref1[la]; e.k1l = kn1[la];
    e.d0r = ref0[ra]; e.k0r = kn0[ra]; e.d1r = ref1[ra]; e.k1r = kn1[ra];
    q.push_back(e);
    tq.push_back(tag);
    if (lc && !lrd && !bl)  begin ref0[la] = ld;   kn0[la] = 1'b1; end
    if (lc && !lrd && !b1l) begin ref1[la] = ~ld;  kn1[la] = 1'b1; end
    if (rc && !rrd && !br)  begin ref0[ra] = rdv;  kn0[ra] = 1'b1; end
    if (rc && !rrd && !b1r) begin ref1[ra] = ~rdv; kn1[ra] = 1'b1; end
    own_r_m = rc && !br;
    if (own_r_m) held_r_m = ra;
  endtask

  task automatic idle();
    cycle(0, 1, 0, '0, '0, 0, 1, 0, '0, '0, 0, 0, "idle");
  endtask

  // Monitor: compare read results one edge after the access
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tq.pop_front();
        chk(l_en0 == e.en_l && l_en1 == e.en_l, {t, " R10 left rd_en"}, {30'd0, l_en0, l_en1}, {30'd0, e.en_l, e.en_l});
        chk(r_en0 == e.en_r && r_en1 == e.en_r, {t, " R10 right rd_en"}, {30'd0, r_en0, r_en1}, {30'd0, e.en_r, e.en_r});
        chk(l_st0 == e.st0l && l_st1 == e.st1l, {t, " R9 left stale"}, {30'd0, l_st0, l_st1}, {30'd0, e.st0l, e.st1l});
        chk(r_st0 == e.st0r && r_st1 == e.st1r, {t, " R9 right stale"}, {30'd0, r_st0, r_st1}, {30'd0, e.st0r, e.st1r});
        if (e.en_l && e.k0l) chk(l_rd0 === e.d0l, {t, " R1 left data master"}, 32'(l_rd0), 32'(e.d0l));
        if (e.en_l && e.k1l) chk(l_rd1 === e.d1l, {t, " R1 left data slave"}, 32'(l_rd1), 32'(e.d1l));
        if (e.en_r && e.k0r) chk(r_rd0 === e.d0r, {t, " R1 right data master"}, 32'(r_rd0), 32'(e.d0r));
        if (e.en_r && e.k1r) chk(r_rd1 === e.d1r, {t, " R1 right data slave"}, 32'(r_rd1), 32'(e.d1r));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R12 watchdog expired", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    l_cs_n = 1'b1; r_cs_n = 1'b1; l_rw = 1'b1; r_rw = 1'b1; l_oe_n = 1'b1; r_oe_n = 1'b1;
    l_addr = '0; r_addr = '0; l_wd = '0; r_wd = '0; pull_l = 1'b0; pull_r = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({l_en0, r_en0, l_st0, r_st0, l_drv0, r_drv0} == 6'd0, "R12 reset outputs master",
        {26'd0, l_en0, r_en0, l_st0, r_st0, l_drv0, r_drv0}, 32'd0);
    chk({l_en1, r_en1, l_st1, r_st1, l_drv1, r_drv1} == 6'd0, "R12 reset outputs slave",
        {26'd0, l_en1, r_en1, l_st1, r_st1, l_drv1, r_drv1}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle();

    // R1 R2 R3: concurrent writes to different words, then cross reads
    cycle(1, 0, 0, 12'h005, 8'h3C, 1, 0, 0, 12'h006, 8'hC3, 0, 0, "R2 dual write");
    cycle(1, 1, 1, 12'h006, 8'h00, 1, 1, 1, 12'h005, 8'h00, 0, 0, "R2 dual read");
    cycle(1, 0, 0, 12'hFFF, 8'h5A, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R1 top write");
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 1, 1, 12'hFFF, 8'h00, 0, 0, "R1 top read");

    // R5 R8: tie on one word, both writing
    idle();
    cycle(1, 0, 0, 12'h009, 8'h11, 1, 0, 0, 12'h009, 8'h22, 0, 0, "R5 tie write");
    cycle(1, 1, 1, 12'h009, 8'h00, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R8 tie readback");

    // R6 R8: right holds a word, left arrives and its write is dropped
    cycle(1, 0, 0, 12'h014, 8'h44, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R6 preset");
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 1, 1, 12'h014, 8'h00, 0, 0, "R6 right takes");
    cycle(1, 0, 0, 12'h014, 8'h77, 1, 1, 1, 12'h014, 8'h00, 0, 0, "R6 left arrives");
    cycle(1, 1, 1, 12'h014, 8'h00, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R8 held readback");

    // R9: right reads a word the left is writing together
    cycle(1, 0, 0, 12'h01E, 8'h66, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R9 preset");
    idle();
    cycle(1, 0, 0, 12'h01E, 8'h55, 1, 1, 1, 12'h01E, 8'h00, 0, 0, "R9 busy read");
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 1, 1, 12'h01E, 8'h00, 0, 0, "R9 new value");

    // R7: owner moves or deselects, busy lifts for the next access
    idle();
    cycle(1, 1, 1, 12'h028, 8'h00, 1, 1, 1, 12'h028, 8'h00, 0, 0, "R7 contend");
    cycle(1, 1, 1, 12'h028, 8'h00, 1, 1, 1, 12'h028, 8'h00, 0, 0, "R7 contend again");
    cycle(1, 1, 1, 12'h029, 8'h00, 1, 1, 1, 12'h028, 8'h00, 0, 0, "R7 owner moved");
    cycle(1, 1, 1, 12'h028, 8'h00, 1, 1, 1, 12'h028, 8'h00, 0, 0, "R7 left returns");
    cycle(1, 1, 1, 12'h028, 8'h00, 0, 1, 0, 12'h000, 8'h00, 0, 0, "R7 right deselects");
    cycle(1, 1, 1, 12'h028, 8'h00, 1, 1, 1, 12'h028, 8'h00, 0, 0, "R7 right back");

    // R10: read with output disabled, and a write, give no rd_en
    cycle(1, 1, 0, 12'h005, 8'h00, 1, 0, 1, 12'h030, 8'h99, 0, 0, "R10 oe off and write");
    idle();

    // R11: slave obeys a line pulled by another block
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 0, 0, 12'h03C, 8'h12, 0, 0, "R11 preset");
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 0, 0, 12'h03C, 8'hAA, 0, 1, "R11 pulled write");
    cycle(0, 1, 0, 12'h000, 8'h00, 1, 1, 1, 12'h03C, 8'h00, 0, 1, "R11 pulled read");
    cycle(1, 0, 0, 12'h03D, 8'h0F, 0, 1, 0, 12'h000, 8'h00, 1, 0, "R11 pulled left write");
    cycle(1, 1, 1, 12'h03D, 8'h00, 1, 1, 1, 12'h03C, 8'h00, 0, 0, "R11 readback");

    // Random concurrent traffic over a small window to force contention
    for (int a = 0; a < 8; a++) cycle(1, 0, 0, 12'(a), 8'(a * 17), 0, 1, 0, '0, '0, 0, 0, "R1 init");
    for (int i = 0; i < 1500; i++) begin
      cycle(($urandom % 4) != 0, $urandom % 2, ($urandom % 5) != 0, 12'($urandom % 8), 8'($urandom),
            ($urandom % 4) != 0, $urandom % 2, ($urandom % 5) != 0, 12'($urandom % 8), 8'($urandom),
            ($urandom % 8) == 0, ($urandom % 8) == 0, "R4 R6 random");
    end
    for (int a = 0; a < 8; a++) cycle(1, 1, 1, 12'(a), '0, 1, 1, 1, 12'(7 - a), '0, 0, 0, "R8 final sweep");
    idle();
    idle();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule